// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when the complete contents of a volatile memory array are copied into a shadow nonvolatile array (a store) and when they are copied back (a recall). A store can start in three ways: automatically when the supply falls below its switch threshold, through an active-low hardware request pin, or through a decoded software command pulse. A recall starts when the supply comes back after power-up or a brown-out, or through a software command pulse.

The block watches a supply-good flag, the request pin, four software command pulses and a write request strobe from the memory port. It drives two inhibit outputs back to that port, an active-low busy line, and single-cycle strobes towards an array model: one that commits a store, one that clears the volatile array, and one that loads the nonvolatile contents back. Every duration is a parameterised count of clock cycles. A dirty flag records whether any write has been accepted since the last completed store or recall. Automatic and pin-requested stores are skipped when the flag is clear. Software stores run whatever the state of the flag.

Top module: `nvseq_ctrl`

## Requirements
- R1: A write strobe accepted while `wr_inhibit` is low marks the array dirty. Completion of a store, or of the load phase of a recall, marks it clean. A strobe presented while `wr_inhibit` is high leaves the flag unchanged.
- R2: Stores requested by supply loss or by the pin are skipped when the array is clean. A `sw_store` pulse in the idle state always starts a store.
- R3: When `pwr_ok` is low in the idle state, with automatic store enabled and the array dirty, a store starts on the next edge. Otherwise the block waits for the supply to return and does not store.
- R4: Reset and every supply-low wait latch a power-up recall. It starts on the first edge at which `pwr_ok` is high, and its load phase lasts PURCL_CYC cycles.
- R5: A falling edge of `hw_req_n` seen in idle with the array dirty opens a grace window of GRACE_CYC cycles. During the window reads stay allowed, and the store begins on the edge after the window ends. `wr_inhibit` is high whenever `hw_req_n` is low.
- R6: `busy_n` is low for exactly STORE_CYC consecutive cycles per store. `store_pulse` is high on the last of them and on no other cycle.
- R7: `acc_inhibit` is high during store, recall and the supply-low wait, and whenever `pwr_ok` is low. It is low in idle and during the grace window. `wr_inhibit` is high whenever `acc_inhibit` is high.
- R8: A recall is one clear cycle with `recall_clear` high, followed by a load phase. The load phase lasts SWRCL_CYC cycles for a software recall and PURCL_CYC cycles for a power-up recall. `recall_load` is high on its last cycle, so it comes exactly that many cycles after `recall_clear`.
- R9: Automatic store is enabled after reset. `sw_auto_off` and `sw_auto_on` change the working setting. Every completed store copies the working setting into a nonvolatile copy, and every power-up recall reloads the working setting from that copy.
- R10: Supply loss takes priority over any software command in the same cycle. Software commands are ignored outside the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; models power-on |
| pwr_ok | input | 1 | Supply above switch threshold |
| hw_req_n | input | 1 | Active-low hardware store request |
| sw_store | input | 1 | Software store command pulse |
| sw_recall | input | 1 | Software recall command pulse |
| sw_auto_off | input | 1 | Software command: disable automatic store |
| sw_auto_on | input | 1 | Software command: enable automatic store |
| wr_req | input | 1 | Write request strobe from the memory port |
| acc_inhibit | output | 1 | Blocks all reads and writes |
| wr_inhibit | output | 1 | Blocks writes |
| busy_n | output | 1 | Low while a store runs (open-drain style) |
| store_pulse | output | 1 | Commit strobe on the last store cycle |
| recall_clear | output | 1 | Clear strobe for the volatile array |
| recall_load | output | 1 | Load strobe on the last recall cycle |

## Verification
The bench builds the sequencer with a grace window of 3 cycles, a store of 5 cycles, a software recall of 4 cycles and a power-up recall of 6 cycles. It uses these values instead of the millisecond-scale defaults. With them, every trigger path can be driven to completion within a few dozen cycles: power loss, the pin, software commands, the persistence of the automatic-store setting across power cycles, and same-cycle priority. Exact durations and gaps can then be compared against small arithmetic expectations. The recall lengths differ on purpose, so that the bench can tell a power-up recall from a software recall.

// File: rtl/nvseq_pkg.sv
`timescale 1ns/1ps
package nvseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRACE,
        ST_STORE,
        ST_RCL_CLR,
        ST_RCL_LOAD,
        ST_PWR_WAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       pu_kind;   // 1: recall belongs to power-up
        logic       auto_en;   // working automatic-store enable
        logic       auto_nv;   // copy held in the nonvolatile array
    } seq_regs_t;

endpackage

// File: rtl/nvseq_timer.sv
`timescale 1ns/1ps
module nvseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nvseq_dirty.sv
`timescale 1ns/1ps
module nvseq_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic wr_block,
    input  logic clear,
    output logic dirty
);
    logic dirty_d, dirty_q;

    always_comb begin
        dirty_d = dirty_q;
        if (clear)
            dirty_d = 1'b0;
        else if (wr_req && !wr_block)
            dirty_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dirty_q <= 1'b0;
        else        dirty_q <= dirty_d;
    end

    assign dirty = dirty_q;
endmodule

// File: rtl/nvseq_ctrl.sv
`timescale 1ns/1ps
module nvseq_ctrl
    import nvseq_pkg::*;
#(
    parameter int unsigned GRACE_CYC = 7000,
    parameter int unsigned STORE_CYC = 1250000,
    parameter int unsigned SWRCL_CYC = 5000,
    parameter int unsigned PURCL_CYC = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic hw_req_n,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sw_auto_off,
    input  logic sw_auto_on,
    input  logic wr_req,
    output logic acc_inhibit,
    output logic wr_inhibit,
    output logic busy_n,
    output logic store_pulse,
    output logic recall_clear,
    output logic recall_load
);
    localparam int unsigned MAX_A = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
    localparam int unsigned MAX_B = (SWRCL_CYC > PURCL_CYC) ? SWRCL_CYC : PURCL_CYC;
    localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW    = (MAX_D < 2) ? 1 : $clog2(MAX_D);

    localparam logic [CW-1:0] GRACE_LD = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_LD = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] SWRCL_LD = CW'(SWRCL_CYC - 1);
    localparam logic [CW-1:0] PURCL_LD = CW'(PURCL_CYC - 1);

    seq_regs_t     r_d, r_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_done;
    logic          dirty;
    logic          dirty_clr;

    nvseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    nvseq_dirty u_dirty (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_block (wr_inhibit),
        .clear    (dirty_clr),
        .dirty    (dirty)
    );

    always_comb begin
        r_d          = r_q;
        t_load       = 1'b0;
        t_val        = '0;
        dirty_clr    = 1'b0;
        store_pulse  = 1'b0;
        recall_clear = 1'b0;
        recall_load  = 1'b0;

        acc_inhibit = !pwr_ok ||
                      !(r_q.state == ST_IDLE || r_q.state == ST_GRACE);
        wr_inhibit  = acc_inhibit || !hw_req_n;
        busy_n      = (r_q.state != ST_STORE);

        case (r_q.state)
            ST_IDLE: begin
                if (!pwr_ok) begin
                    if (r_q.auto_en && dirty) begin
                        r_d.state = ST_STORE;
                        t_load    = 1'b1;
                        t_val     = STORE_LD;
                    end else begin
                        r_d.state = ST_PWR_WAIT;
                    end
                end else if (!hw_req_n) begin
                    if (dirty) begin
                        r_d.state = ST_GRACE;
                        t_load    = 1'b1;
                        t_val     = GRACE_LD;
                    end
                end else if (sw_store) begin
                    r_d.state = ST_STORE;
                    t_load    = 1'b1;
                    t_val     = STORE_LD;
                end else if (sw_recall) begin
                    r_d.state   = ST_RCL_CLR;
                    r_d.pu_kind = 1'b0;
                end else if (sw_auto_off) begin
                    r_d.auto_en = 1'b0;
                end else if (sw_auto_on) begin
                    r_d.auto_en = 1'b1;
                end
            end
            ST_GRACE: begin
                if (!pwr_ok) begin
                    if (r_q.auto_en) begin
                        r_d.state = ST_STORE;
                        t_load    = 1'b1;
                        t_val     = STORE_LD;
                    end else begin
                        r_d.state = ST_PWR_WAIT;
                    end
                end else if (t_done) begin
                    r_d.state = ST_STORE;
                    t_load    = 1'b1;
                    t_val     = STORE_LD;
                end
            end
            ST_STORE: begin
                if (t_done) begin
                    store_pulse = 1'b1;
                    dirty_clr   = 1'b1;
                    r_d.auto_nv = r_q.auto_en;
                    r_d.state   = pwr_ok ? ST_IDLE : ST_PWR_WAIT;
                end
            end
            ST_RCL_CLR: begin
                if (!pwr_ok) begin
                    r_d.state = ST_PWR_WAIT;
                end else begin
                    recall_clear = 1'b1;
                    r_d.state    = ST_RCL_LOAD;
                    t_load       = 1'b1;
                    t_val        = r_q.pu_kind ? PURCL_LD : SWRCL_LD;
                end
            end
            ST_RCL_LOAD: begin
                if (!pwr_ok) begin
                    r_d.state = ST_PWR_WAIT;
                end else if (t_done) begin
                    recall_load = 1'b1;
                    dirty_clr   = 1'b1;
                    r_d.state   = ST_IDLE;
                    if (r_q.pu_kind) r_d.auto_en = r_q.auto_nv;
                end
            end
            ST_PWR_WAIT: begin
                if (pwr_ok) begin
                    r_d.state   = ST_RCL_CLR;
                    r_d.pu_kind = 1'b1;
                end
            end
            default: r_d.state = ST_PWR_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_PWR_WAIT;
            r_q.pu_kind <= 1'b1;
            r_q.auto_en <= 1'b1;
            r_q.auto_nv <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/nvseq_ctrl_chk.sv
`timescale 1ns/1ps
module nvseq_ctrl_chk #(
    parameter int unsigned STORE_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic hw_req_n,
    input logic acc_inhibit,
    input logic wr_inhibit,
    input logic busy_n,
    input logic store_pulse,
    input logic recall_clear,
    input logic recall_load
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (!busy_n) run_q <= run_q + 1;
        else              run_q <= '0;
    end

    p_store_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (run_q == STORE_CYC));

    p_store_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> busy_n);

    p_busy_inh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> acc_inhibit);

    p_supply_inh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (acc_inhibit && wr_inhibit));

    p_pin_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_req_n |-> wr_inhibit);

    p_clr_then_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_clear |=> (acc_inhibit && busy_n && !recall_clear));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_pulse, recall_clear, recall_load}));
endmodule

bind nvseq_ctrl nvseq_ctrl_chk #(.STORE_CYC(STORE_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok       (pwr_ok),
    .hw_req_n     (hw_req_n),
    .acc_inhibit  (acc_inhibit),
    .wr_inhibit   (wr_inhibit),
    .busy_n       (busy_n),
    .store_pulse  (store_pulse),
    .recall_clear (recall_clear),
    .recall_load  (recall_load)
);

// File: tb/nvseq_ctrl_bench.sv
`timescale 1ns/1ps
module nvseq_ctrl_bench;
    localparam int G  = 3;
    localparam int S  = 5;
    localparam int SR = 4;
    localparam int PR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic hw_req_n = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, sw_auto_off = 1'b0, sw_auto_on = 1'b0;
    logic wr_req = 1'b0;
    logic acc_inhibit, wr_inhibit, busy_n, store_pulse, recall_clear, recall_load;

    always #2.5 clk = ~clk;

    nvseq_ctrl #(.GRACE_CYC(G), .STORE_CYC(S), .SWRCL_CYC(SR), .PURCL_CYC(PR)) u_nvseq_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hw_req_n(hw_req_n),
        .sw_store(sw_store), .sw_recall(sw_recall), .sw_auto_off(sw_auto_off),
        .sw_auto_on(sw_auto_on), .wr_req(wr_req),
        .acc_inhibit(acc_inhibit), .wr_inhibit(wr_inhibit), .busy_n(busy_n),
        .store_pulse(store_pulse), .recall_clear(recall_clear), .recall_load(recall_load));

    int checks = 0, errors = 0;
    int n_inh = 0, n_busy = 0, n_st = 0, n_clr = 0, n_ld = 0;
    int cyc = 0, clr_at = 0, gap = -1;
    int s_inh, s_busy, s_st, s_clr, s_ld;
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc    <= cyc + 1;
            n_inh  <= n_inh + int'(acc_inhibit);
            n_busy <= n_busy + int'(!busy_n);
            n_st   <= n_st + int'(store_pulse);
            n_clr  <= n_clr + int'(recall_clear);
            n_ld   <= n_ld + int'(recall_load);
            if (recall_clear) clr_at <= cyc;
            if (recall_load)  gap <= cyc - clr_at;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snap();
        @(negedge clk);
        s_inh = n_inh; s_busy = n_busy; s_st = n_st; s_clr = n_clr; s_ld = n_ld;
        @(posedge clk); #1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: wr_req = 1'b1;
            1: sw_store = 1'b1;
            2: sw_recall = 1'b1;
            3: sw_auto_off = 1'b1;
            default: sw_auto_on = 1'b1;
        endcase
        @(posedge clk); #1;
        wr_req = 1'b0; sw_store = 1'b0; sw_recall = 1'b0;
        sw_auto_off = 1'b0; sw_auto_on = 1'b0;
    endtask

    task automatic power_cycle();
        pwr_ok = 1'b0; wait_n(12);
        pwr_ok = 1'b1; wait_n(12);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state (R7, R6)
        repeat (3) @(negedge clk);
        check("R7 reset inhibit", int'(acc_inhibit), 1);
        check("R6 reset busy_n", int'(busy_n), 1);
        check("R8 reset strobes", int'(store_pulse | recall_clear | recall_load), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // power-up recall after reset (R4, R8)
        wait_n(20);
        check("R4 pu recall clear", n_clr, 1);
        check("R4 pu recall load", n_ld, 1);
        check("R8 pu load gap", gap, PR);
        check("R7 pu inhibit cycles", n_inh, PR + 2);
        check("R9 auto enabled after reset: no store yet", n_st, 0);

        // software store on a clean array (R2, R6)
        snap(); pulse(1); wait_n(12);
        check("R2 sw store runs clean", n_st - s_st, 1);
        check("R6 busy length", n_busy - s_busy, S);
        check("R7 store inhibit cycles", n_inh - s_inh, S);

        // pin request while clean, writes blocked while pin low (R1, R2, R5)
        snap(); hw_req_n = 1'b0; wait_n(1);
        @(negedge clk); check("R5 wr_inhibit pin low", int'(wr_inhibit), 1);
        check("R7 reads allowed pin low", int'(acc_inhibit), 0);
        @(posedge clk); #1; pulse(0); wait_n(10);
        hw_req_n = 1'b1; wait_n(2);
        hw_req_n = 1'b0; wait_n(12); hw_req_n = 1'b1; wait_n(2);
        check("R1 blocked write leaves clean", n_st - s_st, 0);
        check("R2 pin store skipped", n_busy - s_busy, 0);

        // write then pin request: grace then store (R1, R5)
        pulse(0); snap();
        hw_req_n = 1'b0;
        repeat (G) @(posedge clk);
        @(negedge clk);
        check("R5 still in grace", int'(busy_n), 1);
        check("R7 grace not inhibited", int'(acc_inhibit), 0);
        @(negedge clk);
        check("R5 store after grace", int'(busy_n), 0);
        @(posedge clk); #1; wait_n(10); hw_req_n = 1'b1; wait_n(2);
        check("R1 dirty pin store", n_st - s_st, 1);
        check("R7 grace+store inhibit", n_inh - s_inh, S);

        // repeat request after store: clean (R1)
        snap(); hw_req_n = 1'b0; wait_n(12); hw_req_n = 1'b1; wait_n(2);
        check("R1 store cleared dirty", n_st - s_st, 0);

        // software recall (R8, R1)
        pulse(0); snap(); pulse(2); wait_n(10);
        check("R8 sw recall clear", n_clr - s_clr, 1);
        check("R8 sw recall load", n_ld - s_ld, 1);
        check("R8 sw load gap", gap, SR);
        check("R7 sw recall inhibit", n_inh - s_inh, SR + 1);
        snap(); hw_req_n = 1'b0; wait_n(12); hw_req_n = 1'b1; wait_n(2);
        check("R1 recall cleared dirty", n_st - s_st, 0);

        // automatic store on supply loss (R3, R4, R7)
        pulse(0); snap(); pwr_ok = 1'b0; wait_n(1);
        @(negedge clk); check("R7 supply low inhibit", int'(wr_inhibit & acc_inhibit), 1);
        @(posedge clk); #1; wait_n(12);
        check("R3 auto store", n_st - s_st, 1);
        check("R6 auto busy", n_busy - s_busy, S);
        pwr_ok = 1'b1; wait_n(12);
        check("R4 recall after supply return", n_clr - s_clr, 1);
        check("R4 pu gap", gap, PR);

        // supply loss while clean (R3)
        snap(); power_cycle();
        check("R3 clean loss no store", n_st - s_st, 0);
        check("R4 recall after clean loss", n_clr - s_clr, 1);

        // disable without manual store: reverts after power cycle (R9)
        pulse(3); pulse(0); snap(); power_cycle();
        check("R9 disabled no auto store", n_st - s_st, 0);
        pulse(0); snap(); power_cycle();
        check("R9 setting reverted", n_st - s_st, 1);

        // disable then manual store: persists (R9)
        pulse(3); pulse(1); wait_n(10);
        pulse(0); snap(); power_cycle();
        check("R9 persisted off", n_st - s_st, 0);
        pulse(0); snap(); power_cycle();
        check("R9 still off after reload", n_st - s_st, 0);
        pulse(4); pulse(1); wait_n(10);

        // priority: supply loss with sw recall same cycle (R10)
        pulse(0); snap(); pwr_ok = 1'b0; sw_recall = 1'b1;
        @(posedge clk); #1; sw_recall = 1'b0; wait_n(12);
        check("R10 loss beats recall: store", n_st - s_st, 1);
        check("R10 loss beats recall: no clear", n_clr - s_clr, 0);
        pwr_ok = 1'b1; wait_n(12);
        check("R10 pu gap after loss", gap, PR);

        // commands and writes during store ignored (R10, R1)
        snap(); pulse(1); pulse(2); pulse(0); wait_n(12);
        check("R10 recall ignored in store", n_clr - s_clr, 0);
        check("R10 one store", n_st - s_st, 1);
        snap(); hw_req_n = 1'b0; wait_n(12); hw_req_n = 1'b1; wait_n(2);
        check("R1 write during store blocked", n_st - s_st, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule